// File: doc/BRIEF.md
# Saturating Periodic Rate Counter Bank

This block measures how often each trigger bit fires. Every channel has its own counter. The counter adds one on each clock cycle in which its input bit is high, and it holds at its maximum value instead of rolling over. The channels are ordered with the algorithm bits first and the technical bits after them.

A single timer is shared by all channels and marks the end of each measurement window. A 3-bit select picks one of eight window lengths. On the last cycle of a window, every channel copies its count into a snapshot register in the same cycle, and every counter starts the next window. Software reads the snapshots through a simple address/data port, one channel per read. A valid flag tells software that a new set of snapshots is available.

Top module: `rate_cnt_bank`

## Requirements
- R1: Channel k counts the clock cycles in which `trig_i[k]` is high. Channels 0 to N_ALGO-1 carry the algorithm bits and channels N_ALGO to N_ALGO+N_TECH-1 carry the technical bits. Each channel is independent of every other channel.
- R2: A counter that reaches all-ones (0xFFFF at the default CNT_W of 16) holds that value for the rest of the window and never wraps to zero.
- R3: The window length is BASE_CYC << (period_sel_i * LEN_SHIFT) clock cycles. Because period_sel_i is 3 bits wide, there are eight lengths.
- R4: On the boundary cycle, all snapshot registers load their channel's count together, and the counters restart. Between boundaries the snapshots do not change.
- R5: An input that is high on the boundary cycle is counted in the new window, not the closing one. A snapshot therefore covers exactly one window length of input samples.
- R6: When period_sel_i differs from the select in use, the timer restarts at that clock edge. The next boundary comes exactly one new window length later, and no boundary occurs on the edge of the change.
- R7: When rd_en_i is high at a clock edge, rd_data_o shows the snapshot at rd_addr_i after that edge. An address of N_ALGO+N_TECH or above returns zero.
- R8: snap_valid_o goes to 1 after each boundary and goes to 0 after any read. If a read and a boundary happen on the same edge, the flag stays at 1.
- R9: A read on the boundary edge returns the snapshot from the previous window.
- R10: After reset, all counters, all snapshots, rd_data_o and snap_valid_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | N_ALGO+N_TECH | Trigger bits, one per channel, sampled every cycle |
| period_sel_i | input | 3 | Window length select |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | $clog2(N_ALGO+N_TECH) | Channel to read |
| rd_data_o | output | CNT_W | Registered snapshot read data |
| snap_valid_o | output | 1 | New snapshots are available |

## Verification
Two things can happen on the same clock edge: a window boundary, and either a trigger input or a read. The bench changes the select at a known edge, which fixes the cycle of the next boundary. It then raises one trigger bit for exactly the boundary cycle. It expects that hit to be missing from the snapshot taken at that boundary and present in the next one. It also issues a read on the following boundary edge. That read must return the older snapshot while the valid flag stays set, and a second read afterwards must return the newer snapshot.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
  localparam int unsigned SEL_W = 3;
  typedef logic [SEL_W-1:0] per_sel_t;

  function automatic int unsigned win_len(int unsigned base, int unsigned shift, per_sel_t sel);
    return base << (int'(sel) * shift);
  endfunction
endpackage

// File: rtl/rcb_period_timer.sv
module rcb_period_timer
  import rcb_pkg::*;
#(
  parameter int unsigned BASE_CYC  = 256,
  parameter int unsigned LEN_SHIFT = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  per_sel_t sel_i,
  output logic     tick_o
);
  localparam int unsigned MAX_LEN = BASE_CYC << (((1 << SEL_W) - 1) * LEN_SHIFT);
  localparam int unsigned TW      = $clog2(MAX_LEN);

  per_sel_t        sel_q;
  logic [TW-1:0]   tmr_q;
  logic [31:0]     last_c;
  logic            chg_c;

  assign last_c = win_len(BASE_CYC, LEN_SHIFT, sel_q) - 32'd1;
  assign chg_c  = (sel_i != sel_q);
  assign tick_o = !chg_c && (32'(tmr_q) == last_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      tmr_q <= '0;
    end else if (chg_c) begin
      sel_q <= sel_i;
      tmr_q <= '0;
    end else if (tick_o) begin
      tmr_q <= '0;
    end else begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_c |=> (tmr_q == '0));
  p_no_tick_on_chg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_c |-> !tick_o);
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (tmr_q == '0) && $stable(sel_q));
endmodule

// File: rtl/rcb_channel.sv
module rcb_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] snap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else if (tick_i) begin
      snap_q <= cnt_q;
      cnt_q  <= CNT_W'(hit_i);  // boundary-cycle hit opens the new window
    end else if (hit_i && (cnt_q != '1)) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign snap_o = snap_q;

  p_no_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && (cnt_q == '1)) |=> (cnt_q == '1));
  p_boundary_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_q == CNT_W'($past(hit_i))));
  p_snap_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (snap_q == $past(cnt_q)));
  p_snap_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(snap_q));
endmodule

// File: rtl/rcb_read_port.sv
module rcb_read_port #(
  parameter int unsigned N_CH  = 192,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned AW    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [N_CH*CNT_W-1:0] snap_i,
  input  logic                  rd_en_i,
  input  logic [AW-1:0]         rd_addr_i,
  output logic [CNT_W-1:0]      rd_data_o,
  output logic                  valid_o
);
  logic [CNT_W-1:0] mux_c;
  logic [CNT_W-1:0] data_q;
  logic             valid_q;
  logic             in_rng_c;

  assign in_rng_c = (32'(rd_addr_i) < N_CH);

  always_comb begin
    mux_c = '0;
    if (in_rng_c) mux_c = snap_i[int'(rd_addr_i)*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (rd_en_i) data_q <= mux_c;
      if (tick_i)       valid_q <= 1'b1;  // update beats a same-cycle read
      else if (rd_en_i) valid_q <= 1'b0;
    end
  end

  assign rd_data_o = data_q;
  assign valid_o   = valid_q;

  p_valid_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> valid_q);
  p_valid_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !tick_i) |=> !valid_q);
  p_oob_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !in_rng_c) |=> (data_q == '0));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(data_q));
endmodule

// File: rtl/rate_cnt_bank.sv
module rate_cnt_bank
  import rcb_pkg::*;
#(
  parameter int unsigned N_ALGO    = 128,
  parameter int unsigned N_TECH    = 64,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BASE_CYC  = 256,
  parameter int unsigned LEN_SHIFT = 2,
  localparam int unsigned N_CH     = N_ALGO + N_TECH,
  localparam int unsigned AW       = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   trig_i,
  input  logic [SEL_W-1:0]  period_sel_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              snap_valid_o
);
  logic                  tick;
  logic [N_CH*CNT_W-1:0] snap_flat;

  rcb_period_timer #(
    .BASE_CYC (BASE_CYC),
    .LEN_SHIFT(LEN_SHIFT)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (period_sel_i),
    .tick_o(tick)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    rcb_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick),
      .hit_i (trig_i[k]),
      .snap_o(snap_flat[k*CNT_W +: CNT_W])
    );
  end

  rcb_read_port #(
    .N_CH (N_CH),
    .CNT_W(CNT_W),
    .AW   (AW)
  ) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .snap_i   (snap_flat),
    .rd_en_i  (rd_en_i),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o),
    .valid_o  (snap_valid_o)
  );
endmodule

// File: tb/sim_rate_cnt_bank.sv
`timescale 1ns/1ps
module sim_rate_cnt_bank;
  localparam int unsigned N_ALGO = 3, N_TECH = 2, CNT_W = 8;
  localparam int unsigned BASE = 4, SHF = 1;
  localparam int unsigned N_CH = N_ALGO + N_TECH;
  localparam int unsigned AW = $clog2(N_CH);
  localparam int unsigned MAXV = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_CH-1:0] trig;
  logic [2:0] sel = 3'd7;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [CNT_W-1:0] rd_data;
  logic valid;
  logic pat_on = 1'b0;
  logic [N_CH-1:0] man = '0;
  int unsigned cyc = 0;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  // ch0, ch4 always high; ch1 idle; ch2 every other cycle; ch3 one in four
  assign trig = pat_on ? {1'b1, (cyc[1:0] == 2'd0), cyc[0], 1'b0, 1'b1} : man;

  rate_cnt_bank #(.N_ALGO(N_ALGO), .N_TECH(N_TECH), .CNT_W(CNT_W),
                  .BASE_CYC(BASE), .LEN_SHIFT(SHF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .period_sel_i(sel),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .snap_valid_o(valid));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); rd_en = 1'b1; rd_addr = AW'(a);
    @(negedge clk); rd_en = 1'b0; d = int'(rd_data);
  endtask

  task automatic wait_valid();
    while (!valid) @(negedge clk);
  endtask

  task automatic t_reset();
    int d;
    check("R10 valid", int'(valid), 0);
    check("R10 rd_data", int'(rd_data), 0);
    rd(0, d); check("R10 snapshot", d, 0);
  endtask

  task automatic t_rates(int code);
    int d, len, e;
    len = BASE << (code * SHF);
    pat_on = 1'b1; sel = 3'(code);
    rd(0, d); wait_valid();
    rd(0, d); wait_valid();
    rd(0, d); e = (len > MAXV) ? MAXV : len;
    check(len > MAXV ? "R2 sat ch0" : "R1/R3 ch0", d, e);
    rd(1, d); check("R1 idle ch1", d, 0);
    rd(2, d); check("R1/R3 half ch2", d, len / 2);
    rd(3, d); check("R1/R4 quarter ch3", d, len / 4);
    rd(4, d); check(len > MAXV ? "R2 sat tech ch4" : "R1 tech ch4", d, e);
  endtask

  // boundary hit and read/update collision on a known edge
  task automatic t_boundary();
    int d, len;
    len = BASE << (3 * SHF);
    pat_on = 1'b0; man = '0;
    @(negedge clk); sel = 3'd3;
    @(posedge clk);                         // E: timer restarts
    @(negedge clk); rd_en = 1'b1; rd_addr = 1;
    @(posedge clk);                         // E+1
    @(negedge clk); rd_en = 1'b0;
    check("R8 cleared by read", int'(valid), 0);
    repeat (len - 2) @(posedge clk);        // E+L-1
    @(negedge clk); check("R6 no early boundary", int'(valid), 0);
    man[1] = 1'b1;
    @(posedge clk);                         // E+L boundary
    @(negedge clk); man[1] = 1'b0;
    check("R6 boundary L after change", int'(valid), 1);
    rd_en = 1'b1; rd_addr = 1;
    @(posedge clk);                         // E+L+1
    @(negedge clk); rd_en = 1'b0;
    check("R5 hit excluded from closing window", int'(rd_data), 0);
    repeat (len - 2) @(posedge clk);        // E+2L-1
    @(negedge clk); rd_en = 1'b1; rd_addr = 1;
    @(posedge clk);                         // E+2L boundary + read
    @(negedge clk); rd_en = 1'b0;
    check("R9 read on boundary gives old", int'(rd_data), 0);
    check("R8 update wins over read", int'(valid), 1);
    rd(1, d); check("R5 hit in new window", d, 1);
    check("R8 cleared after read", int'(valid), 0);
    rd(0, d); check("R1 quiet channel", d, 0);
  endtask

  task automatic t_oob();
    int d;
    rd(N_CH, d); check("R7 out of range", d, 0);
    rd(7, d); check("R7 top address", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rates(3);
    t_rates(4);
    t_rates(5);
    t_rates(6);
    t_boundary();
    pat_on = 1'b1;
    t_oob();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule